// File: doc/BRIEF.md
# Strided Rectangular Block Mover

This engine copies a rectangle of data between a small local scratch memory and a large external word-addressed memory. The local memory is split into two 4 KB halves: a data half (local address bit 12 clear) and an instruction half (bit 12 set). One pulse on `start` launches a transfer in the direction chosen by `to_ext`. The transfer is set by three values: a local base address, an external base address and one packed 32-bit shape word. The shape word gives the bytes per row, the number of rows, and an extra gap that the external address skips after each row.

The engine moves one 32-bit word per beat. Each beat uses a valid/ready handshake on the external side. Bytes are reversed for words in the data half. Words in the instruction half keep their byte order. When the transfer ends, the two address registers hold the positions that follow the last row, so a caller can chain transfers without reloading them.

Top module: `rowdma`

## Requirements
- R1: The row length in bytes is `len_cfg[11:0] + 1`, rounded up to the next multiple of 8.
- R2: `len_cfg[19:12]` plus one rows are moved. Each row is row-length/4 word beats.
- R3: After each row, the local register grows by the row length. The external register grows by the row length plus `len_cfg[31:20]` (the skip). `loc_addr_out` and `ext_addr_out` show these registers, and they change only at row ends.
- R4: At start, bits [1:0] of the local address and bits [2:0] of the external address are cleared.
- R5: The row length is computed once at start. If the aligned local offset within its 4 KB half plus the row length is greater than 0x1000, the row length becomes 0x1000 minus that offset. A row that ends exactly at 0x1000 is not shortened.
- R6: Beat k of a row uses local address `(loc + 4k) mod 0x2000` and external address `(ext + 4k) mod 0x800000`. Both addresses have bits [1:0] forced to zero.
- R7: If the beat's local address has bit 12 clear, the word is byte-reversed ({b0,b1,b2,b3} from {b3,b2,b1,b0}). If bit 12 is set, the word passes unchanged. This holds in both directions.
- R8: `busy` rises in the cycle after an accepted start pulse. It falls in the cycle after the handshake of the final beat. While `busy` is high, `start` is ignored, and no local or external access happens while `busy` is low.
- R9: `ext_valid`, `ext_addr`, `ext_wdata` and `ext_write` stay steady until `ext_ready` is sampled high.
- R10: With `to_ext`=0, external words are read (`ext_write`=0). Each word is written locally in the cycle its handshake completes. With `to_ext`=1, each word is read from local memory (one-cycle read latency) and then offered as an external write (`ext_write`=1).
- R11: After reset, `busy`, `ext_valid` and `loc_en` are low, and both address outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse |
| to_ext | input | 1 | 1: local to external, 0: external to local |
| loc_addr_in | input | 32 | Local base byte address |
| ext_addr_in | input | 32 | External base byte address |
| len_cfg | input | 32 | Shape word: skip[31:20], rows-1[19:12], bytes-1[11:0] |
| busy | output | 1 | Transfer in progress |
| loc_addr_out | output | 32 | Local address register |
| ext_addr_out | output | 32 | External address register |
| ext_valid | output | 1 | External beat request |
| ext_ready | input | 1 | External beat accepted |
| ext_write | output | 1 | External beat is a write |
| ext_addr | output | 23 | External word byte address |
| ext_wdata | output | 32 | External write data |
| ext_rdata | input | 32 | External read data, valid with ready |
| loc_en | output | 1 | Local memory access |
| loc_we | output | 1 | Local memory write |
| loc_addr | output | 13 | Local word byte address |
| loc_wdata | output | 32 | Local write data |
| loc_rdata | input | 32 | Local read data, one cycle after access |

## Verification
The embedded properties check, on every cycle, that a stalled external request holds its address, data and direction. They also check that the engine does nothing while idle, that an accepted start raises `busy`, and that the address registers stay put between row ends. Only the bench's scenarios can show the arithmetic. This covers the rounding and clamping of the row length, the per-beat address sequence including wrap at the top of external space, byte reversal by half, the final register values, and that a start pulse mid-transfer changes nothing.

// File: rtl/rowdma.sv
module rowdma #(
  parameter int LOC_AW = 13,
  parameter int EXT_AW = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              to_ext,
  input  logic [31:0]       loc_addr_in,
  input  logic [31:0]       ext_addr_in,
  input  logic [31:0]       len_cfg,
  output logic              busy,
  output logic [31:0]       loc_addr_out,
  output logic [31:0]       ext_addr_out,
  output logic              ext_valid,
  input  logic              ext_ready,
  output logic              ext_write,
  output logic [EXT_AW-1:0] ext_addr,
  output logic [31:0]       ext_wdata,
  input  logic [31:0]       ext_rdata,
  output logic              loc_en,
  output logic              loc_we,
  output logic [LOC_AW-1:0] loc_addr,
  output logic [31:0]       loc_wdata,
  input  logic [31:0]       loc_rdata
);
  localparam int HB = LOC_AW - 1;
  localparam int LW = LOC_AW;
  localparam logic [LW:0] HALF = (LW+1)'(1) << HB;

  typedef enum logic [1:0] {IDLE, FETCH, CAP, XFER} st_t;
  st_t st;

  logic          dir_q;
  logic [31:0]   loc_q, ext_q, buf_q;
  logic [LW-1:0] len_q, j_q;
  logic [11:0]   skip_q;
  logic [7:0]    cnt_q, row_q;

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  wire [LW-1:0] len_raw = {{(LW-12){1'b0}}, len_cfg[11:0]} + LW'(1);
  wire [LW-1:0] len_rnd = (len_raw + LW'(7)) & ~LW'(7);
  wire [LW-1:0] off     = {1'b0, loc_addr_in[HB-1:2], 2'b00};
  wire [LW:0]   reach   = {1'b0, off} + {1'b0, len_rnd};
  wire [LW:0]   room    = HALF - {1'b0, off};
  wire [LW-1:0] len_fit = (reach > HALF) ? room[LW-1:0] : len_rnd;

  wire [LW:0]       j_nxt    = {1'b0, j_q} + (LW+1)'(4);
  wire              last_wd  = j_nxt >= {1'b0, len_q};
  wire              last_row = row_q == cnt_q;
  wire [LOC_AW-1:0] loc_beat = loc_q[LOC_AW-1:0] + j_q;
  wire [EXT_AW-1:0] ext_beat = ext_q[EXT_AW-1:0] + EXT_AW'(j_q);
  wire              instr    = loc_addr[HB];
  wire              fire     = (st == XFER) && ext_ready;

  assign busy         = st != IDLE;
  assign loc_addr_out = loc_q;
  assign ext_addr_out = ext_q;
  assign loc_addr     = loc_beat & ~LOC_AW'(3);
  assign ext_addr     = ext_beat & ~EXT_AW'(3);
  assign ext_valid    = st == XFER;
  assign ext_write    = dir_q;
  assign ext_wdata    = buf_q;
  assign loc_we       = fire && !dir_q;
  assign loc_en       = (st == FETCH) || loc_we;
  assign loc_wdata    = instr ? ext_rdata : bswap(ext_rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      dir_q  <= 1'b0;
      loc_q  <= '0;
      ext_q  <= '0;
      buf_q  <= '0;
      len_q  <= '0;
      j_q    <= '0;
      skip_q <= '0;
      cnt_q  <= '0;
      row_q  <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          dir_q  <= to_ext;
          loc_q  <= loc_addr_in & ~32'd3;
          ext_q  <= ext_addr_in & ~32'd7;
          len_q  <= len_fit;
          skip_q <= len_cfg[31:20];
          cnt_q  <= len_cfg[19:12];
          row_q  <= '0;
          j_q    <= '0;
          st     <= to_ext ? FETCH : XFER;
        end
        FETCH: st <= CAP;
        CAP: begin
          buf_q <= instr ? loc_rdata : bswap(loc_rdata);
          st    <= XFER;
        end
        XFER: if (ext_ready) begin
          if (last_wd) begin
            j_q   <= '0;
            loc_q <= loc_q + 32'(len_q);
            ext_q <= ext_q + 32'(len_q) + 32'(skip_q);
            if (last_row) st <= IDLE;
            else begin
              row_q <= row_q + 8'd1;
              st    <= dir_q ? FETCH : XFER;
            end
          end else begin
            j_q <= j_nxt[LW-1:0];
            st  <= dir_q ? FETCH : XFER;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && !ext_ready |=> ext_valid && $stable(ext_addr) && $stable(ext_wdata) && $stable(ext_write));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ext_valid && !loc_en);

  p_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);

  p_regs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(ext_valid && ext_ready) |=> $stable(loc_addr_out) && $stable(ext_addr_out));
endmodule

// File: tb/sim_rowdma.sv
module sim_rowdma;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, to_ext = 1'b0;
  logic [31:0] loc_addr_in = '0, ext_addr_in = '0, len_cfg = '0;
  logic        busy, ext_valid, ext_write, loc_en, loc_we;
  logic        ext_ready = 1'b1;
  logic [31:0] loc_addr_out, ext_addr_out, ext_wdata, ext_rdata, loc_wdata;
  logic [31:0] loc_rdata = '0;
  logic [22:0] ext_addr;
  logic [12:0] loc_addr;

  always #2 clk = ~clk;

  rowdma u0 (.clk, .rst_n, .start, .to_ext, .loc_addr_in, .ext_addr_in, .len_cfg,
    .busy, .loc_addr_out, .ext_addr_out, .ext_valid, .ext_ready, .ext_write,
    .ext_addr, .ext_wdata, .ext_rdata, .loc_en, .loc_we, .loc_addr, .loc_wdata, .loc_rdata);

  integer nchk = 0, nerr = 0;

  function automatic logic [31:0] sw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
  function automatic logic [31:0] fl(input logic [10:0] i);
    return {8'hAA, i[7:0], 8'h55, 5'b0, i[10:8]};
  endfunction
  function automatic logic [31:0] fe(input logic [22:0] a);
    return {8'h5A, 1'b0, a};
  endfunction

  assign ext_rdata = fe(ext_addr);

  logic [31:0] lmem [2048];
  always_ff @(posedge clk) begin
    if (loc_en && loc_we) lmem[loc_addr[12:2]] <= loc_wdata;
    if (loc_en && !loc_we) loc_rdata <= lmem[loc_addr[12:2]];
  end

  logic [15:0] lfsr = 16'hACE1;
  logic        stall_mode = 1'b0;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ext_ready = stall_mode ? lfsr[0] : 1'b1;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (!ok) begin
      nerr = nerr + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [12:0] exp_la [1024];
  logic [22:0] exp_ea [1024];
  integer      nbeat = 0, kbeat = 0;
  logic        exp_dir = 1'b0, mon_on = 1'b0;
  logic [31:0] exp_lo, exp_eo;

  task automatic plan(input logic d, input logic [31:0] la, input logic [31:0] ea, input logic [31:0] cfg);
    logic [31:0] len, off, lb, eb;
    len = ((cfg[11:0] + 32'd1) + 32'd7) & ~32'd7;
    lb  = la & ~32'd3;
    eb  = ea & ~32'd7;
    off = lb & 32'hFFF;
    if (off + len > 32'h1000) len = 32'h1000 - off;
    nbeat = 0;
    for (int r = 0; r <= int'(cfg[19:12]); r++) begin
      for (int j = 0; j < int'(len); j += 4) begin
        exp_la[nbeat] = 13'((lb + 32'(j)) & 32'h1FFC);
        exp_ea[nbeat] = 23'((eb + 32'(j)) & 32'h7FFFFC);
        nbeat = nbeat + 1;
      end
      lb = lb + len;
      eb = eb + len + 32'(cfg[31:20]);
    end
    exp_lo = lb; exp_eo = eb; exp_dir = d; kbeat = 0;
  endtask

  logic        was_stall = 1'b0;
  logic [22:0] st_ea;
  logic [31:0] st_wd;
  always @(negedge clk) if (mon_on) begin
    if (was_stall && ext_valid)
      chk(ext_addr == st_ea && ext_wdata == st_wd, "R9 stall hold", {9'b0, ext_addr}, {9'b0, st_ea});
    was_stall = ext_valid && !ext_ready;
    st_ea = ext_addr; st_wd = ext_wdata;
    if (ext_valid && ext_ready) begin
      if (kbeat < nbeat) begin
        chk(ext_write == exp_dir, "R10 direction", {31'b0, ext_write}, {31'b0, exp_dir});
        chk(ext_addr == exp_ea[kbeat] && loc_addr == exp_la[kbeat], "R6 beat address",
            {loc_addr[11:0], ext_addr[19:0]}, {exp_la[kbeat][11:0], exp_ea[kbeat][19:0]});
        if (!exp_dir) begin
          chk(loc_en && loc_we, "R10 local write on handshake", {31'b0, loc_we}, 32'd1);
          chk(loc_wdata == (exp_la[kbeat][12] ? fe(exp_ea[kbeat]) : sw(fe(exp_ea[kbeat]))),
              "R7 read data order", loc_wdata,
              exp_la[kbeat][12] ? fe(exp_ea[kbeat]) : sw(fe(exp_ea[kbeat])));
        end else begin
          chk(ext_wdata == (exp_la[kbeat][12] ? fl(exp_la[kbeat][12:2]) : sw(fl(exp_la[kbeat][12:2]))),
              "R7 write data order", ext_wdata,
              exp_la[kbeat][12] ? fl(exp_la[kbeat][12:2]) : sw(fl(exp_la[kbeat][12:2])));
        end
      end
      kbeat = kbeat + 1;
    end
  end

  typedef struct packed {
    logic        d;
    logic        stall;
    logic [31:0] la;
    logic [31:0] ea;
    logic [31:0] cfg;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'h0000_0010, 32'h0000_1000, {12'h008, 8'd2, 12'h00F}},
    '{1'b1, 1'b1, 32'h0000_1020, 32'h0000_2000, {12'h010, 8'd1, 12'h00B}},
    '{1'b0, 1'b1, 32'h0000_0FF3, 32'h0000_3005, {12'h000, 8'd1, 12'h01F}},
    '{1'b1, 1'b0, 32'h0000_0804, 32'h007F_FFF8, {12'h000, 8'd0, 12'h00F}},
    '{1'b0, 1'b0, 32'h0000_1FF8, 32'h0000_0040, {12'h000, 8'd0, 12'h000}},
    '{1'b1, 1'b1, 32'h0000_0100, 32'h0000_0500, {12'h003, 8'd3, 12'h007}},
    '{1'b0, 1'b0, 32'h0000_0F00, 32'h0000_8000, {12'h000, 8'd0, 12'hFFF}}
  };

  task automatic launch(input vec_t v);
    for (int i = 0; i < 2048; i++) lmem[i] = fl(11'(i));
    plan(v.d, v.la, v.ea, v.cfg);
    stall_mode = v.stall;
    mon_on = 1'b1;
    @(negedge clk);
    to_ext = v.d; loc_addr_in = v.la; ext_addr_in = v.ea; len_cfg = v.cfg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R8 busy after start", {31'b0, busy}, 32'd1);
  endtask

  task automatic finish_run;
    while (busy) @(negedge clk);
    chk(kbeat == nbeat, "R1 R2 R5 beat count", 32'(kbeat), 32'(nbeat));
    chk(loc_addr_out == exp_lo, "R3 R4 local register", loc_addr_out, exp_lo);
    chk(ext_addr_out == exp_eo, "R3 R4 external register", ext_addr_out, exp_eo);
    mon_on = 1'b0;
    was_stall = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    nerr = nerr + 1;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !ext_valid && !loc_en, "R11 reset idle", {29'b0, busy, ext_valid, loc_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(loc_addr_out == 0 && ext_addr_out == 0, "R11 reset registers", loc_addr_out | ext_addr_out, 32'd0);
    chk(!busy, "R8 idle before start", {31'b0, busy}, 32'd0);

    for (int n = 0; n < NV; n++) begin
      launch(VECS[n]);
      finish_run();
    end

    // R8: a second start while busy must not disturb the running transfer
    launch(VECS[0]);
    repeat (2) @(negedge clk);
    to_ext = 1'b1; loc_addr_in = 32'h0000_0400; ext_addr_in = 32'h0000_9000;
    len_cfg = {12'h100, 8'd5, 12'h03F}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_run();
    chk(!busy, "R8 busy falls after last beat", {31'b0, busy}, 32'd0);

    // R8: busy drops in the cycle after the final handshake
    launch(VECS[4]);
    while (!(ext_valid && ext_ready)) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(!busy, "R8 busy drop timing", {31'b0, busy}, 32'd0);
    finish_run();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule